// File: doc/BRIEF.md
# Posted Store Buffer with Drain-Side Word Splitting

This block sits between a processor's store port and a slower memory write port. The core presents a store of one, two or four bytes at any byte address. While the buffer has room, the store is taken in the cycle it is presented, so the core carries on without waiting for memory. Pending stores are held in a small first-in first-out queue and written out whenever memory raises ready.

A store that straddles a 32-bit word boundary takes only one queue slot. The drain side turns it into two aligned word writes with byte enables. The extra bus cycle therefore slows the drain rather than the core. The core only sees it later, as a full-queue stall if stores keep arriving. An empty flag lets surrounding logic wait until every posted store has reached memory.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer is empty: `buf_empty` is 1, `mem_valid` is 0 and `st_ready` is 1.
- R2: While fewer than DEPTH stores are pending, `st_ready` is 1 and a presented store is taken at that clock edge.
- R3: While DEPTH stores are pending and the final write of the oldest store does not complete in this cycle, `st_ready` is 0 and the presented store is not taken.
- R4: While DEPTH stores are pending and the final write of the oldest store completes in this cycle (`mem_valid` and `mem_ready` both 1), `st_ready` is 1 and the new store is taken.
- R5: A write shown on the memory port while `mem_ready` is 0 stays presented, with unchanged address, byte enables and data, until `mem_ready` is 1.
- R6: Size codes are 0 for one byte, 1 for two bytes and 2 for four bytes. Data bytes are taken from the low end of `st_data`. A store that fits in one word gives one write. Its address is the store address with bits 1:0 cleared. Byte lane k (`mem_be[k]`, `mem_wdata[8k+7:8k]`) is enabled for each byte whose address has low bits equal to k.
- R7: A store whose bytes cross a word boundary gives two writes. The first goes to the lower word and carries the bytes that fall in it. The second goes to the lower word's address plus 4 and carries the remaining bytes in the low lanes.
- R8: Writes leave in the order the stores were taken. Both writes of a split store complete before the next store's first write.
- R9: `buf_empty` is 1 exactly when no store is pending, including the cycles between the two writes of a split store.
- R10: Every write has `mem_addr[1:0]` equal to 0 and at least one byte enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | Core presents a store |
| st_ready | output | 1 | Store taken this edge when both are high |
| st_addr | input | 32 | Byte address of the store |
| st_size | input | 2 | 0 byte, 1 halfword, 2 word |
| st_data | input | 32 | Store data, low bytes used |
| mem_valid | output | 1 | A write is presented to memory |
| mem_ready | input | 1 | Memory accepts the presented write |
| mem_addr | output | 32 | Word-aligned write address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data by lane |
| buf_empty | output | 1 | No store pending |

## Verification
The first pattern sends sparse aligned stores with memory always ready. Each store should then give a single write and the core should never stall, which separates correct lane placement from any splitting error. Dense stores at random byte offsets against a mostly busy memory fill the queue. They show whether the stall arises only when the queue is full, and whether a store that crosses a word keeps one slot while costing two writes. A long stretch with memory held off, followed by release, checks that presented writes stay steady and that the queue refills in step with the final write of each store. A long random mix then tests ordering and the same-cycle refill at every occupancy.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int OFF_W   = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } st_size_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        st_size_e          size;
        logic [DATA_W-1:0] data;
    } st_entry_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] data;
    } bus_beat_t;

    function automatic logic [LANES-1:0] lane_mask(input st_size_e sz);
        case (sz)
            SZ_BYTE: lane_mask = 4'b0001;
            SZ_HALF: lane_mask = 4'b0011;
            default: lane_mask = 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/sb_fifo.sv
module sb_fifo
    import sb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                push,
    input  st_entry_t           wr_entry,
    input  logic                pop,
    output st_entry_t           head,
    output logic [$clog2(DEPTH+1)-1:0] occ
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    st_entry_t       slots [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        bump = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= wr_entry;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop)
                rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   occ <= occ + CW'(1);
                2'b01:   occ <= occ - CW'(1);
                default: occ <= occ;
            endcase
        end
    end

    assign head = slots[rd_ptr];
endmodule

// File: rtl/sb_drain.sv
module sb_drain
    import sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              have_entry,
    input  st_entry_t         head,
    input  logic              mem_ready,
    output bus_beat_t         beat,
    output logic              beat_valid,
    output logic              retire
);
    logic                    upper_q;
    logic [OFF_W-1:0]        off;
    logic [2*LANES-1:0]      wide_be;
    logic [2*DATA_W-1:0]     wide_d;
    logic [ADDR_W-1:0]       word_addr;
    logic                    spills;
    logic                    fire;

    always_comb begin
        off       = head.addr[OFF_W-1:0];
        wide_be   = {{LANES{1'b0}}, lane_mask(head.size)} << off;
        wide_d    = {{DATA_W{1'b0}}, head.data} << (8 * off);
        word_addr = {head.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        spills    = |wide_be[2*LANES-1:LANES];
        if (upper_q) begin
            beat.addr = word_addr + ADDR_W'(LANES);
            beat.be   = wide_be[2*LANES-1:LANES];
            beat.data = wide_d[2*DATA_W-1:DATA_W];
        end else begin
            beat.addr = word_addr;
            beat.be   = wide_be[LANES-1:0];
            beat.data = wide_d[DATA_W-1:0];
        end
    end

    assign beat_valid = have_entry;
    assign fire       = have_entry && mem_ready;
    assign retire     = fire && (upper_q || !spills);

    always_ff @(posedge clk) begin
        if (rst)
            upper_q <= 1'b0;
        else if (fire)
            upper_q <= !upper_q && spills;
    end
endmodule

// File: rtl/store_buffer.sv
module store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        st_valid,
    output logic        st_ready,
    input  logic [31:0] st_addr,
    input  logic [1:0]  st_size,
    input  logic [31:0] st_data,
    output logic        mem_valid,
    input  logic        mem_ready,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    output logic        buf_empty
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] occ;
    st_entry_t     in_entry, head;
    bus_beat_t     beat;
    logic          push, retire, have_entry;

    assign in_entry.addr = st_addr;
    assign in_entry.size = st_size_e'(st_size);
    assign in_entry.data = st_data;

    assign have_entry = (occ != '0);
    assign st_ready   = (occ != CW'(DEPTH)) || retire;
    assign push       = st_valid && st_ready;
    assign buf_empty  = !have_entry;

    sb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .wr_entry (in_entry),
        .pop      (retire),
        .head     (head),
        .occ      (occ)
    );

    sb_drain u_drain (
        .clk        (clk),
        .rst        (rst),
        .have_entry (have_entry),
        .head       (head),
        .mem_ready  (mem_ready),
        .beat       (beat),
        .beat_valid (mem_valid),
        .retire     (retire)
    );

    assign mem_addr  = beat.addr;
    assign mem_be    = beat.be;
    assign mem_wdata = beat.data;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       st_ready,
    input  logic                       mem_valid,
    input  logic                       mem_ready,
    input  logic [31:0]                mem_addr,
    input  logic [3:0]                 mem_be,
    input  logic [31:0]                mem_wdata,
    input  logic                       buf_empty,
    input  logic [$clog2(DEPTH+1)-1:0] occ
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= ($clog2(DEPTH+1))'(DEPTH)); // R3
    AST_FREE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (occ < ($clog2(DEPTH+1))'(DEPTH)) |-> st_ready); // R2
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
        (occ == ($clog2(DEPTH+1))'(DEPTH) && !(mem_valid && mem_ready)) |-> !st_ready); // R3
    AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_be) && $stable(mem_wdata))); // R5
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        buf_empty |-> !mem_valid); // R9
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[1:0] == 2'b00 && mem_be != 4'b0000)); // R10
endmodule

bind store_buffer sb_checker #(.DEPTH(DEPTH)) u_sb_checker (
    .clk       (clk),
    .rst       (rst),
    .st_ready  (st_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .buf_empty (buf_empty),
    .occ       (occ)
);

// File: tb/test_store_buffer.sv
module test_store_buffer;
    localparam int DEPTH  = 2;
    localparam int CYCLES = 2600;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic [1:0]  st_size = '0;
    logic [31:0] st_data = '0;
    logic        mem_ready = 1'b0;
    logic        st_ready, mem_valid, buf_empty;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;

    int checks = 0;
    int errors = 0;

    store_buffer #(.DEPTH(DEPTH)) i_store_buffer (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .buf_empty(buf_empty)
    );

    always #4 clk = ~clk;

    // reference queue of pending stores
    logic [31:0] q_addr[$];
    logic [1:0]  q_size[$];
    logic [31:0] q_data[$];
    int          m_half = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // builds one expected bus write byte by byte
    task automatic make_piece(input logic [31:0] a, input logic [1:0] sz,
                              input logic [31:0] d, input int hi,
                              output logic [31:0] pa, output logic [3:0] be,
                              output logic [31:0] pd);
        int n;
        n  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        pa = {a[31:2], 2'b00} + (hi != 0 ? 32'd4 : 32'd0);
        be = '0;
        pd = '0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] ba;
            ba = a + i;
            if ({ba[31:2], 2'b00} == pa) begin
                be[ba[1:0]]        = 1'b1;
                pd[8*ba[1:0] +: 8] = d[8*i +: 8];
            end
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] e_addr, e_data, p_addr, p_data, hold_addr, hold_data;
        logic [3:0]  e_be, p_be, hold_be;
        bit          e_valid, e_ready, two, last, hold_pending;
        int          cnt;
        hold_pending = 0;
        hold_addr = '0; hold_be = '0; hold_data = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(buf_empty == 1'b1, "R1", "buf_empty after reset", 32'(buf_empty), 32'd1);
        check(mem_valid == 1'b0, "R1", "mem_valid after reset", 32'(mem_valid), 32'd0);
        check(st_ready  == 1'b1, "R1", "st_ready after reset", 32'(st_ready), 32'd1);

        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            int pv, pr;
            @(negedge clk);
            if (cyc < 200)       begin pv = 30;  pr = 100; end
            else if (cyc < 500)  begin pv = 90;  pr = 20;  end
            else if (cyc < 560)  begin pv = 100; pr = 0;   end
            else if (cyc < 700)  begin pv = 100; pr = 100; end
            else                 begin pv = 50;  pr = 50;  end
            st_valid  = ($urandom_range(99) < pv);
            st_size   = 2'($urandom_range(2));
            st_data   = $urandom;
            st_addr   = {16'h0, 16'($urandom)};
            if (cyc < 200)
                st_addr[1:0] = (st_size == 2'd2) ? 2'b00 :
                               (st_size == 2'd1) ? {st_addr[1], 1'b0} : st_addr[1:0];
            mem_ready = ($urandom_range(99) < pr);
            #1;

            cnt     = q_addr.size();
            e_valid = (cnt != 0);
            two     = 0;
            if (e_valid) begin
                make_piece(q_addr[0], q_size[0], q_data[0], 1, p_addr, p_be, p_data);
                two = (p_be != 4'b0000);
                make_piece(q_addr[0], q_size[0], q_data[0], m_half, e_addr, e_be, e_data);
            end
            last    = e_valid && (m_half == 1 || !two);
            e_ready = (cnt < DEPTH) || (last && mem_ready);

            check(buf_empty == (cnt == 0), "R9", "buf_empty", 32'(buf_empty), 32'(cnt == 0));
            check(mem_valid == e_valid, "R8", "mem_valid", 32'(mem_valid), 32'(e_valid));
            if (cnt < DEPTH)
                check(st_ready == e_ready, "R2", "st_ready not full", 32'(st_ready), 32'(e_ready));
            else if (e_ready)
                check(st_ready == 1'b1, "R4", "st_ready on final drain", 32'(st_ready), 32'd1);
            else
                check(st_ready == 1'b0, "R3", "st_ready full", 32'(st_ready), 32'd0);
            if (e_valid && mem_valid) begin
                check(mem_addr == e_addr, "R8", "mem_addr order", mem_addr, e_addr);
                check(mem_addr[1:0] == 2'b00 && mem_be != 0, "R10", "alignment", mem_addr, e_addr);
                check(mem_be == e_be, two ? "R7" : "R6", "mem_be", 32'(mem_be), 32'(e_be));
                for (int k = 0; k < 4; k++)
                    if (e_be[k])
                        check(mem_wdata[8*k +: 8] == e_data[8*k +: 8], two ? "R7" : "R6",
                              "mem_wdata lane", mem_wdata, e_data);
            end
            if (hold_pending)
                check(mem_valid && mem_addr == hold_addr && mem_be == hold_be
                      && mem_wdata == hold_data, "R5", "held write", mem_addr, hold_addr);
            hold_pending = mem_valid && !mem_ready;
            hold_addr = mem_addr; hold_be = mem_be; hold_data = mem_wdata;

            @(posedge clk);
            if (e_valid && mem_ready) begin
                if (m_half == 0 && two) m_half = 1;
                else begin
                    m_half = 0;
                    void'(q_addr.pop_front());
                    void'(q_size.pop_front());
                    void'(q_data.pop_front());
                end
            end
            if (st_valid && e_ready) begin
                q_addr.push_back(st_addr);
                q_size.push_back(st_size);
                q_data.push_back(st_data);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule